// File: doc/BRIEF.md
# MMU Control Register File

This block stores the control state that a processor's address-translation unit and exception logic consult: the translation control word, the three page-table-entry staging words (high, low, assist), the translation-table base, the faulting address, the trap code and the two event codes. Software reaches them through a simple word-addressed port with separate read and write strobes. Each register keeps only the bits that have meaning for it.

Two writes also have side effects, which leave the block as single-cycle pulses for the translation logic. Writing the control word with its invalidate bit set requests a full TLB invalidate. That bit is never stored. Writing the page-entry-high word with a new address-space identifier requests a TLB flush. Writing the same identifier again does not. The translation logic itself lies outside this block.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, every register holds zero, and `rdata`, `err`, `tlb_inval` and `tlb_flush` are all low.
- R2: A write to the control word (offset 0) with bit 2 of `wdata` set drives `tlb_inval` high for exactly the cycle after the write. The stored control word holds all written bits except bit 2, which always reads as 0.
- R3: A write to page-entry-high (offset 1) drives `tlb_flush` high for the cycle after the write only when `wdata[7:0]` differs from the stored bits [7:0]. All 32 bits are stored in either case.
- R4: Page-entry-assist (offset 3) keeps only `wdata[3:0]`. Bits [31:4] read as 0.
- R5: Trap code (offset 6), exception event (offset 7) and interrupt event (offset 8) keep only `wdata[10:0]`. Bits [31:11] read as 0.
- R6: Page-entry-low (offset 2), table base (offset 4) and exception address (offset 5) store all 32 bits unmasked.
- R7: A read strobe at a mapped offset presents the stored value on `rdata` in the next cycle. If a write to the same offset happens in that same cycle, the read returns the value from before the write. In a cycle that follows no read, `rdata` is 0.
- R8: An access to any offset from 9 upward raises `err` for the next cycle. A read there returns 0. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (4) | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| err | output | 1 | Access to an unmapped offset, one cycle |
| tlb_inval | output | 1 | TLB invalidate request pulse |
| tlb_flush | output | 1 | TLB flush request pulse on identifier change |

## Verification
The assertions assume that the strobes and `addr` are sampled only at rising edges and are held at 0 throughout reset. This matters because the pulse checks look one cycle back to the access that caused them. They also assume that a read and a write issued in the same cycle target the same offset whenever both are used. The bench drives every input on the falling edge, keeps the strobes low during reset, and only ever pairs a read with a write to a single shared offset.

// File: rtl/mmu_regs_pkg.sv
// Package: shared constants and the per-register field masks of the MMU
// control register file. Assumes a 32-bit data path and word offsets.
package mmu_regs_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_REGS  = 9;
    localparam int INVAL_BIT = 2;
    localparam int ASID_W    = 8;
    localparam int ASSIST_W  = 4;
    localparam int EVT_W     = 11;

    typedef enum int {
        IDX_CTRL    = 0,
        IDX_PTE_HI  = 1,
        IDX_PTE_LO  = 2,
        IDX_PTE_AST = 3,
        IDX_TBASE   = 4,
        IDX_EXC_ADR = 5,
        IDX_TRAP    = 6,
        IDX_EXC_EVT = 7,
        IDX_INT_EVT = 8
    } reg_idx_e;

    // Bits each register retains on a write.
    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        logic [DATA_W-1:0] m;
        m = '1;
        case (idx)
            IDX_CTRL:    m[INVAL_BIT] = 1'b0;
            IDX_PTE_AST: m = {{(DATA_W-ASSIST_W){1'b0}}, {ASSIST_W{1'b1}}};
            IDX_TRAP,
            IDX_EXC_EVT,
            IDX_INT_EVT: m = {{(DATA_W-EVT_W){1'b0}}, {EVT_W{1'b1}}};
            default:     m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mmu_addr_decode.sv
// Module: turns a word offset into a one-hot register select.
// Assumes NUM_REGS fits in the offset range; offsets beyond it select nothing.
module mmu_addr_decode #(
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 9
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);

    // One-hot compare of the offset against each register index.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i)) sel[i] = 1'b1;
        end
    end

    assign hit = |sel;

endmodule

// File: rtl/mmu_reg_bank.sv
// Module: storage for all registers, each one masked to its own field width,
// plus the combinational read mux. Assumes sel is one-hot or zero.
module mmu_reg_bank
    import mmu_regs_pkg::*;
#(
    parameter int NREGS = NUM_REGS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [NREGS-1:0]              sel,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NREGS-1:0][DATA_W-1:0]  regs_q,
    output logic [DATA_W-1:0]             rd_word
);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = field_mask(g);
        // Capture the masked write data for this register.
        always_ff @(posedge clk) begin
            if (!rst_n)                  regs_q[g] <= '0;
            else if (wr_en && sel[g])    regs_q[g] <= wdata & MASK;
        end
    end

    // Select the addressed register for a read; zero when nothing is selected.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (sel[i]) rd_word = rd_word | regs_q[i];
        end
    end

endmodule

// File: rtl/mmu_side_effects.sv
// Module: produces the one-cycle TLB invalidate and flush request pulses.
// Assumes the caller qualifies the selects with the write strobe semantics.
module mmu_side_effects
    import mmu_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel_ctrl,
    input  logic              sel_pte_hi,
    input  logic              wbit_inval,
    input  logic [ASID_W-1:0] wasid,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              tlb_inval,
    output logic              tlb_flush
);

    logic inval_d;
    logic flush_d;

    assign inval_d = wr_en && sel_ctrl && wbit_inval;
    assign flush_d = wr_en && sel_pte_hi && (wasid != cur_asid);

    // Register both requests so each lasts one clock after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tlb_inval <= 1'b0;
            tlb_flush <= 1'b0;
        end else begin
            tlb_inval <= inval_d;
            tlb_flush <= flush_d;
        end
    end

    // R3: a flush pulse follows only a page-entry-high write.
    p_flush_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> $past(wr_en && sel_pte_hi));

endmodule

// File: rtl/mmu_ctrl_regs.sv
// Module: top of the MMU control register file. Decodes word offsets,
// holds masked registers, registers read data and error, and raises the
// TLB side-effect pulses. Assumes single-cycle strobes sampled at rising edges.
module mmu_ctrl_regs
    import mmu_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err,
    output logic              tlb_inval,
    output logic              tlb_flush
);

    logic [NUM_REGS-1:0]             sel;
    logic                            hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]               rd_word;

    mmu_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .addr (addr),
        .sel  (sel),
        .hit  (hit)
    );

    mmu_reg_bank #(.NREGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (wdata),
        .regs_q  (regs_q),
        .rd_word (rd_word)
    );

    mmu_side_effects u_fx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .sel_ctrl   (sel[IDX_CTRL]),
        .sel_pte_hi (sel[IDX_PTE_HI]),
        .wbit_inval (wdata[INVAL_BIT]),
        .wasid      (wdata[ASID_W-1:0]),
        .cur_asid   (regs_q[IDX_PTE_HI][ASID_W-1:0]),
        .tlb_inval  (tlb_inval),
        .tlb_flush  (tlb_flush)
    );

    // Register the read result and the unmapped-access flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= rd_en ? rd_word : '0;
            err   <= (rd_en || wr_en) && !hit;
        end
    end

    // R2: an invalidating control write is followed by the pulse.
    p_inval_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(IDX_CTRL) && wdata[INVAL_BIT]) |=> tlb_inval);

    // R2: the pulse has no other cause.
    p_inval_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inval |-> $past(wr_en && addr == ADDR_W'(IDX_CTRL) && wdata[INVAL_BIT]));

    // R5: event-code reads never carry bits above the field.
    p_evt_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr >= ADDR_W'(IDX_TRAP) && addr <= ADDR_W'(IDX_INT_EVT))
        |-> rdata[31:EVT_W] == '0);

    // R7: without a read in the previous cycle the data bus is quiet.
    p_idle_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> rdata == '0);

    // R8: the error flag follows only accesses past the last register.
    p_err_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past((rd_en || wr_en) && addr >= ADDR_W'(NUM_REGS)));

endmodule

// File: tb/mmu_ctrl_regs_test.sv
`timescale 1ns/1ps
module mmu_ctrl_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err, tlb_inval, tlb_flush;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] model [9];
    logic [31:0] exp_rdata = '0;
    logic        exp_err = 1'b0, exp_inval = 1'b0, exp_flush = 1'b0;
    string       tag = "R1";

    always #2 clk = ~clk;

    mmu_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err),
        .tlb_inval(tlb_inval), .tlb_flush(tlb_flush)
    );

    function automatic logic [31:0] keep_bits(input int idx, input logic [31:0] d);
        if (idx == 0) return d & 32'hFFFF_FFFB;
        if (idx == 3) return d & 32'h0000_000F;
        if (idx >= 6) return d & 32'h0000_07FF;
        return d;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Compare the previous cycle's expectation, then drive and predict one cycle.
    task automatic step(input string t, input bit w, input bit r,
                        input int a, input logic [31:0] d);
        @(negedge clk);
        check("rdata", rdata, exp_rdata);
        check("err", {31'b0, err}, {31'b0, exp_err});
        check("tlb_inval", {31'b0, tlb_inval}, {31'b0, exp_inval});
        check("tlb_flush", {31'b0, tlb_flush}, {31'b0, exp_flush});
        tag = t;
        wr_en = w; rd_en = r; addr = 4'(a); wdata = d;
        exp_rdata = (r && a < 9) ? model[a] : 32'h0;
        exp_err   = (w || r) && a >= 9;
        exp_inval = w && a == 0 && d[2];
        exp_flush = w && a == 1 && (d[7:0] != model[1][7:0]);
        if (w && a < 9) model[a] = keep_bits(a, d);
    endtask

    task automatic rd(input string t, input int a);
        step(t, 1'b0, 1'b1, a, 32'h0);
    endtask

    task automatic wr(input string t, input int a, input logic [31:0] d);
        step(t, 1'b1, 1'b0, a, d);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 9; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state across every register.
        for (int i = 0; i < 9; i++) rd("R1", i);
        // R2: invalidate bit pulses and is dropped.
        wr("R2", 0, 32'hA5A5_5A5F);
        rd("R2", 0);
        wr("R2", 0, 32'h0000_0011);
        rd("R2", 0);
        wr("R2", 0, 32'h0000_0004);
        wr("R2", 0, 32'h0000_0004);
        rd("R2", 0);
        // R3: flush only on identifier change.
        wr("R3", 1, 32'h1234_5600);
        wr("R3", 1, 32'h1234_5642);
        wr("R3", 1, 32'hFFFF_FF42);
        rd("R3", 1);
        wr("R3", 1, 32'h0000_0043);
        rd("R3", 1);
        // R4: assist width.
        wr("R4", 3, 32'hFFFF_FFFF);
        rd("R4", 3);
        // R5: event-code widths.
        wr("R5", 6, 32'hDEAD_BEEF);
        wr("R5", 7, 32'hFFFF_FFFF);
        wr("R5", 8, 32'h0000_0800);
        rd("R5", 6); rd("R5", 7); rd("R5", 8);
        // R6: full-width registers.
        wr("R6", 2, 32'hCAFE_F00D);
        wr("R6", 4, 32'h8000_0001);
        wr("R6", 5, 32'hFFFF_FFFF);
        rd("R6", 2); rd("R6", 4); rd("R6", 5);
        // R7: read alongside a write returns the old value, then idle.
        step("R7", 1'b1, 1'b1, 4, 32'h1111_2222);
        step("R7", 1'b0, 1'b0, 0, 32'h0);
        rd("R7", 4);
        // R8: unmapped offsets.
        rd("R8", 9);
        wr("R8", 12, 32'hFFFF_FFFF);
        rd("R8", 15);
        for (int i = 0; i < 9; i++) rd("R8", i);
        step("R8", 1'b0, 1'b0, 0, 32'h0);
        step("R8", 1'b0, 1'b0, 0, 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule